// File: doc/BRIEF.md
# Cascadable Synchronous Preset Binary Counter

This block counts upward in binary on the rising edge of a single clock. It is built from 4-bit stages. Each stage has an active-low synchronous clear, an active-low synchronous parallel load and two active-high count enables. The top module chains a parameterised number of stages, so together they behave as one counter that is four times that number of bits wide.

A count enable goes to every stage in parallel. A carry enable enters the lowest stage. Each higher stage takes its carry enable from the terminal-count output of the stage below it. That output depends only on the carry enable and the stage's own bits, so the slower count-enable path never ripples through the chain.

When several controls are active at once, the first match in this order wins: clear, then load, then count, then hold. The register has no power-on reset. Its value is undefined until the first clocked clear or load.

Top module: `casc_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, every bit of `q` becomes 0 after that edge, whatever `ld_n`, `cnt_en` and `cry_en` are doing.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `q` takes the value of `din` after that edge, bit i to bit i with bit 0 as the least significant. This applies whatever the enables are and whatever the current count is, including all ones.
- R3: When `clr_n` and `ld_n` are high and both `cnt_en` and `cry_en` are high, `q` increases by exactly one at the rising edge.
- R4: When `clr_n` and `ld_n` are high and `cnt_en` is low, `q` keeps its value across the edge, even if `cry_en` is high.
- R5: When `clr_n` and `ld_n` are high and `cry_en` is low, `q` keeps its value across the edge, even if `cnt_en` is high.
- R6: Counting from the all-ones value gives all zeros, with no extra state in between.
- R7: `tc` is high exactly when `cry_en` is high and every bit of `q` is 1. It follows `cry_en` combinationally within the same cycle and does not depend on `cnt_en`.
- R8: Across a 4-bit stage boundary, the chained stages count as one binary number. For example, 0x0F counts to 0x10 and 0x10 holds when the enables are low.
- R9: `q` changes only at a rising clock edge. A clear or load applied in the middle of a cycle has no effect on `q` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable, fanned out to every stage |
| cry_en | input | 1 | Carry enable into the lowest stage; also gates `tc` |
| din | input | 4*NSTAGES | Parallel load data, bit 0 is the least significant |
| q | output | 4*NSTAGES | Counter value, bit 0 is the least significant |
| tc | output | 1 | Terminal count: `cry_en` high and `q` all ones |

## Verification
The hardest conditions to reach are those where modes collide at the top of the range. Examples are a load while the count sits at all ones with both enables high, and the carry output observed with the count enable low. Random stimulus alone seldom produces these.

The bench therefore steers into them with directed loads, such as loading all ones and loading 0x0F to cross a stage boundary. It then runs a long random phase with clear and load weighted low and the enables weighted high. That phase passes through many carries between stages and many wraps from all ones to zero.

// File: rtl/counter_pkg.sv
package counter_pkg;

    // Bits held by one chainable stage.
    localparam int STAGE_W = 4;

    // Operating mode of a stage, listed from lowest to highest precedence.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } mode_e;

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import counter_pkg::*;
(
    input  logic  clr_n,
    input  logic  ld_n,
    input  logic  cnt_en,
    input  logic  cry_en,
    output mode_e mode
);

    // Fixed precedence: clear, then load, then count, then hold.
    always_comb begin
        if (!clr_n) begin
            mode = MODE_CLEAR;
        end else if (!ld_n) begin
            mode = MODE_LOAD;
        end else if (cnt_en && cry_en) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import counter_pkg::*;
#(
    parameter int W = STAGE_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         cnt_en,
    input  logic         cry_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         cry_out
);

    typedef struct packed {
        logic [W-1:0] val;
    } stage_state_t;

    stage_state_t st_d;
    stage_state_t st_q;
    mode_e        mode;

    cnt_mode_dec u_dec (
        .clr_n  (clr_n),
        .ld_n   (ld_n),
        .cnt_en (cnt_en),
        .cry_en (cry_en),
        .mode   (mode)
    );

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_CLEAR: st_d.val = '0;
            MODE_LOAD:  st_d.val = din;
            MODE_COUNT: st_d.val = st_q.val + 1'b1;
            default:    st_d.val = st_q.val;
        endcase
    end

    // No power-on reset: the state is defined by the first clear or load.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q       = st_q.val;
    assign cry_out = cry_en & (&st_q.val);

endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import counter_pkg::*;
#(
    parameter int NSTAGES = 2
) (
    input  logic                         clk,
    input  logic                         clr_n,
    input  logic                         ld_n,
    input  logic                         cnt_en,
    input  logic                         cry_en,
    input  logic [STAGE_W*NSTAGES-1:0]   din,
    output logic [STAGE_W*NSTAGES-1:0]   q,
    output logic                         tc
);

    localparam int TOTAL_W = STAGE_W * NSTAGES;

    // chain[k] is the carry enable of stage k; chain[NSTAGES] leaves the top stage.
    logic [NSTAGES:0] chain;

    assign chain[0] = cry_en;

    for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
        cnt_stage #(
            .W (STAGE_W)
        ) u_stage (
            .clk     (clk),
            .clr_n   (clr_n),
            .ld_n    (ld_n),
            .cnt_en  (cnt_en),
            .cry_en  (chain[k]),
            .din     (din[k*STAGE_W +: STAGE_W]),
            .q       (q[k*STAGE_W +: STAGE_W]),
            .cry_out (chain[k+1])
        );
    end

    assign tc = chain[NSTAGES];

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic         ld_n,
    input logic         cnt_en,
    input logic         cry_en,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         tc
);

    // The state becomes defined after the first clocked clear or load.
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n || !ld_n) begin
            armed_q <= 1'b1;
        end
    end

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> (q == '0));

    assert_load_copy_R2: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_n) |=> (q == $past(din)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && cnt_en && cry_en) |=> (q == W'($past(q) + 1'b1)));

    assert_hold_cnt_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && !cnt_en) |=> $stable(q));

    assert_hold_cry_R5: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && !cry_en) |=> $stable(q));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && cnt_en && cry_en && (&q)) |=> (q == '0));

    assert_tc_match_R7: assert property (@(posedge clk) disable iff (!armed_q)
        tc == (cry_en && (&q)));

endmodule

bind casc_counter casc_counter_chk #(.W(TOTAL_W)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .ld_n   (ld_n),
    .cnt_en (cnt_en),
    .cry_en (cry_en),
    .din    (din),
    .q      (q),
    .tc     (tc)
);

// File: tb/tb_casc_counter.sv
`timescale 1ns/1ps
module tb_casc_counter;

    localparam int NST  = 2;
    localparam int W    = 4 * NST;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         ld_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic         cry_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         tc;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit known  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    casc_counter #(.NSTAGES(NST)) dut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en),
        .cry_en(cry_en), .din(din), .q(q), .tc(tc)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(bit c, bit l, bit ce, bit ye, int m);
        if (!c) return "R1";
        if (!l) return "R2";
        if (ce && ye) return (m == MAXV) ? "R6" : "R3";
        if (!ce) return "R4";
        return "R5";
    endfunction

    // One cycle: drive, check tc and q before the edge, clock, check q after.
    task automatic cyc(input bit c, input bit l, input bit ce, input bit ye,
                       input int d, input string tag);
        string t;
        clr_n = c; ld_n = l; cnt_en = ce; cry_en = ye; din = W'(d);
        #0.5;
        if (known) begin
            check(int'(tc), int'(ye && model == MAXV), "R7 tc");
            check(int'(q), model, "R9 q before edge");
        end
        t = (tag == "") ? mode_tag(c, l, ce, ye, model) : tag;
        @(posedge clk);
        if (!c) begin
            model = 0; known = 1;
        end else if (!l) begin
            model = d & MAXV; known = 1;
        end else if (ce && ye) begin
            model = (model + 1) & MAXV;
        end
        #1;
        if (known) check(int'(q), model, t);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        cyc(0, 0, 1, 1, 8'hAA, "R1 clear with load");
        cyc(1, 0, 1, 1, 8'hFF, "R2 load all ones");
        cyc(1, 1, 0, 1, 0, "R4 count enable low");
        check(int'(tc), 1, "R7 tc with cnt_en low");
        cyc(1, 1, 1, 0, 0, "R5 carry enable low");
        check(int'(tc), 0, "R7 tc gated by cry_en");
        cyc(1, 0, 1, 1, 8'h3C, "R2 load at terminal count");
        cyc(1, 0, 0, 0, 8'hFF, "R2 load");
        cyc(1, 1, 1, 1, 0, "R6 wrap to zero");
        cyc(1, 0, 1, 1, 8'h0F, "R2 load");
        cyc(1, 1, 1, 1, 0, "R8 stage boundary");
        cyc(1, 1, 0, 0, 0, "R8 hold across stages");
        cyc(1, 0, 0, 0, 8'h5A, "R2 bit mapping");
        cyc(0, 1, 1, 1, 0, "R1 clear over count");
        for (int i = 0; i < 600; i++) begin
            bit c  = ($urandom_range(0, 19) != 0);
            bit l  = ($urandom_range(0, 15) != 0);
            bit ce = ($urandom_range(0, 3) != 0);
            bit ye = ($urandom_range(0, 3) != 0);
            int d  = (($urandom_range(0, 5) == 0) ? MAXV : int'($urandom_range(0, MAXV)));
            cyc(c, l, ce, ye, d, "");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule